// File: doc/BRIEF.md
# Configuration Bitstream Frame Generator

This block turns a sequence of configuration frame descriptors into one serial configuration stream. A pulse on `start` captures the stream options and sends a header. The header is made of dummy ones, the preamble nibble `0010`, a 24-bit length count taken from an input, and more dummy ones. An optional identification frame may follow the header. After that come the data frames, one for each descriptor accepted over a valid/ready handshake. The stream closes with a fixed end word and a run of postamble ones. Each frame opens with a zero start bit and a 16-bit frame head. The head holds the data-frame flag, the compressed flag, two parity bits and an 11-bit column address. Frames are separated by runs of stop ones.

Uncompressed frames carry alignment zeros, a write bit and the data word. Compressed frames carry only the head. A byte-aligned option changes the dummy counts and the stop counts. With it the same stream can also feed a loader that takes eight bits at a time, and the preamble lands in a byte of its own that reads `11110010`.

The stream leaves the block one bit per clock, most significant bit of every field first. The consumer paces it through `bit_ready`.

Top module: `cfg_stream_framer`

## Requirements
- R1: After reset `busy`, `bit_valid` and `desc_ready` are all low, and they stay low until `start`.
- R2: With `byte_mode` low at `start`, the header is 4 ones, then `0010`, then `total_bits[23:0]` with the MSB first, then 4 ones.
- R3: With `byte_mode` high at `start`, the header is 12 ones, then `0010`, then the 24-bit length, then 8 ones. This puts the preamble byte `11110010` on a byte boundary.
- R4: Every frame starts with the bits 0, P, C, Opar, Epar, then the 11-bit address with the MSB first. For a data frame, P is the inverse of `desc_all` and C equals `desc_comp`.
- R5: Parity covers the 13-bit vector {P, C, addr}, with addr[0] at index 0. Opar makes the count of ones at the odd indices, plus Opar, odd. Epar makes the count of ones at the even indices, plus Epar, even.
- R6: When `id_en` is high at `start`, the header is followed by a frame with P=1, C=0 and address 11'h7FF. Its head is followed by `parity_en`, 43 zeros and `part_id[19:0]` (MSB first), then 3 stop ones, or 8 in byte mode. When `id_en` is low, no such frame is sent.
- R7: After its head, an uncompressed frame carries ALIGN_ZEROS zeros, a single 1 and the DATA_W data bits (MSB first). It is followed by STOP_BITS ones when not in byte mode.
- R8: A compressed frame sends its head and then its stop ones directly. `desc_data` has no effect on it.
- R9: In byte mode every data frame is followed by STOP_BITS rounded up to a multiple of 8 ones.
- R10: After the frame whose descriptor had `desc_last` set, the block sends `0010011111111111`, then POST_ONES ones. It then drops `busy` and sends no further bits.
- R11: While `bit_valid` is high and `bit_ready` is low, `bit_out` holds its value. `desc_ready` is high only between frames after the header (and the ID frame, if any) has been sent. Each descriptor handshake yields exactly one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a stream while idle; the options below are captured with it |
| byte_mode | input | 1 | Selects the byte-aligned dummy and stop counts |
| id_en | input | 1 | Sends the identification frame |
| parity_en | input | 1 | Value of the parity-enable bit in the identification frame |
| part_id | input | 20 | Identifier placed in the identification frame |
| total_bits | input | 24 | Value sent in the length count field |
| desc_valid | input | 1 | A frame descriptor is offered |
| desc_ready | output | 1 | The block takes a descriptor |
| desc_addr | input | 11 | Column address of the frame |
| desc_comp | input | 1 | Compressed frame (address only) |
| desc_all | input | 1 | Marks the all-frames-written case (P bit cleared) |
| desc_last | input | 1 | This is the final frame of the stream |
| desc_data | input | DATA_W | Frame data for uncompressed frames |
| bit_out | output | 1 | Serial stream bit |
| bit_valid | output | 1 | `bit_out` carries a stream bit |
| bit_ready | input | 1 | The consumer takes the bit at this clock edge |
| busy | output | 1 | A stream is in progress |

## Verification
The first header bit is valid in the cycle after the clock edge that takes `start`. A frame's first bit is valid in the cycle after its descriptor handshake. Between two segments there is one idle cycle with `bit_valid` low. The bench does not depend on these cycle counts for content. A scoreboard compares each bit, in order, at the falling edge of every cycle in which `bit_valid` and `bit_ready` are both high, so gaps and consumer stalls do not shift the comparison. The hold rule is checked at the falling edge one cycle after a stall is seen. The end of a stream is checked a few cycles after `busy` falls: by then the expected queue must be empty and `bit_valid` low.

// File: rtl/cfg_stream_pkg.sv
// Package: shared constants, state type and small elaboration helpers for
// the configuration stream framer. Assumes fields are sent MSB first.
package cfg_stream_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_IDF,
        ST_DWAIT,
        ST_DFRM,
        ST_ENDW
    } seq_state_e;

    localparam int ADDR_W  = 11;
    localparam int LEN_W   = 24;
    localparam int PID_W   = 20;
    localparam int RSVD_W  = 43;
    localparam int FLD_W   = ADDR_W + 2;       // {P, C, addr} parity field
    localparam int HEAD_W  = FLD_W + 3;        // start, P, C, Opar, Epar, addr
    localparam int END_W   = 16;
    localparam int HCORE_W = 4 + LEN_W;        // preamble + length

    localparam logic [3:0]       PREAMBLE = 4'b0010;
    localparam logic [END_W-1:0] END_WORD = 16'b0010011111111111;

    // Round a bit count up to the next multiple of eight.
    function automatic int round8(input int n);
        return ((n + 7) / 8) * 8;
    endfunction

    // Larger of two counts.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_frame_parity.sv
// Module: computes the two frame parity bits over a field vector.
// opar makes ones at odd indices plus opar odd; epar makes ones at even
// indices plus epar even. Purely combinational.
module cfg_frame_parity #(
    parameter int W = 13
) (
    input  logic [W-1:0] fields,
    output logic         opar,
    output logic         epar
);

    logic [W-1:0] odd_mask;

    // Build the odd-index selection mask.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign odd_mask[i] = (i % 2) == 1;
    end

    // Reduce the selected halves into the two parity bits.
    always_comb begin
        opar = ~(^(fields & odd_mask));
        epar = ^(fields & ~odd_mask);
    end

endmodule

// File: rtl/cfg_bit_shifter.sv
// Module: holds one stream segment (left-aligned, MSB first) and shifts it
// out one bit per accepted cycle. Assumes load is raised only when empty.
module cfg_bit_shifter #(
    parameter int SEG_W = 96,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEG_W-1:0] load_val,
    input  logic [CNT_W-1:0] load_len,
    input  logic             out_ready,
    output logic             out_bit,
    output logic             out_valid,
    output logic             empty
);

    logic [SEG_W-1:0] sreg;
    logic [CNT_W-1:0] cnt;

    // Load a new segment or advance by one accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (load) begin
            sreg <= load_val;
            cnt  <= load_len;
        end else if (cnt != '0 && out_ready) begin
            sreg <= {sreg[SEG_W-2:0], 1'b1};
            cnt  <= cnt - 1'b1;
        end
    end

    // Present the head bit and the occupancy flags.
    always_comb begin
        out_bit   = sreg[SEG_W-1];
        out_valid = cnt != '0;
        empty     = cnt == '0;
    end

    // R11
    shift_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !load |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/cfg_stream_framer.sv
// Module: top of the configuration stream framer. A sequencer picks the next
// segment (header, ID frame, data frame, end word) and hands it to the bit
// shifter. Assumes descriptors arrive only after desc_ready; options are
// captured on start while idle.
module cfg_stream_framer
    import cfg_stream_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ALIGN_ZEROS = 2,
    parameter int STOP_BITS   = 3,
    parameter int POST_ONES   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_mode,
    input  logic              id_en,
    input  logic              parity_en,
    input  logic [PID_W-1:0]  part_id,
    input  logic [LEN_W-1:0]  total_bits,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic              desc_comp,
    input  logic              desc_all,
    input  logic              desc_last,
    input  logic [DATA_W-1:0] desc_data,
    output logic              bit_out,
    output logic              bit_valid,
    input  logic              bit_ready,
    output logic              busy
);

    localparam int STOP_B = round8(STOP_BITS);
    localparam int FR_U   = HEAD_W + ALIGN_ZEROS + 1 + DATA_W;
    localparam int IDF_W  = HEAD_W + 1 + RSVD_W + PID_W;
    localparam int SEG_W  = imax(imax(FR_U + STOP_B, IDF_W + 8), END_W + POST_ONES);
    localparam int CNT_W  = $clog2(SEG_W + 1);

    localparam logic [CNT_W-1:0] HDR_LEN_N = CNT_W'(4 + HCORE_W + 4);
    localparam logic [CNT_W-1:0] HDR_LEN_B = CNT_W'(12 + HCORE_W + 8);
    localparam logic [CNT_W-1:0] IDF_LEN_N = CNT_W'(IDF_W + 3);
    localparam logic [CNT_W-1:0] IDF_LEN_B = CNT_W'(IDF_W + 8);
    localparam logic [CNT_W-1:0] STP_LEN_N = CNT_W'(STOP_BITS);
    localparam logic [CNT_W-1:0] STP_LEN_B = CNT_W'(STOP_B);
    localparam logic [CNT_W-1:0] FRU_LEN   = CNT_W'(FR_U);
    localparam logic [CNT_W-1:0] FRC_LEN   = CNT_W'(HEAD_W);
    localparam logic [CNT_W-1:0] END_LEN   = CNT_W'(END_W + POST_ONES);

    seq_state_e        state_q, state_d;
    logic              byte_q, id_q, pen_q, last_q;
    logic [PID_W-1:0]  pid_q;
    logic              sh_load, sh_empty;
    logic [SEG_W-1:0]  sh_val, hdr_seg, idf_seg, frm_seg, end_seg;
    logic [CNT_W-1:0]  sh_len, hdr_len, idf_len, frm_len;
    logic [FLD_W-1:0]  frm_fld, idf_fld;
    logic              frm_opar, frm_epar, idf_opar, idf_epar;
    logic [HEAD_W-1:0] frm_head, idf_head;

    assign frm_fld = {~desc_all, desc_comp, desc_addr};
    assign idf_fld = {1'b1, 1'b0, {ADDR_W{1'b1}}};

    cfg_frame_parity #(.W(FLD_W)) u_frm_par (
        .fields(frm_fld), .opar(frm_opar), .epar(frm_epar)
    );

    cfg_frame_parity #(.W(FLD_W)) u_idf_par (
        .fields(idf_fld), .opar(idf_opar), .epar(idf_epar)
    );

    // Assemble the left-aligned segment images, unused tail bits left as ones.
    always_comb begin
        frm_head = {1'b0, frm_fld[FLD_W-1 -: 2], frm_opar, frm_epar, desc_addr};
        idf_head = {1'b0, idf_fld[FLD_W-1 -: 2], idf_opar, idf_epar, idf_fld[ADDR_W-1:0]};

        hdr_seg = '1;
        if (byte_mode) begin
            hdr_seg[SEG_W-13 -: HCORE_W] = {PREAMBLE, total_bits};
            hdr_len = HDR_LEN_B;
        end else begin
            hdr_seg[SEG_W-5 -: HCORE_W]  = {PREAMBLE, total_bits};
            hdr_len = HDR_LEN_N;
        end

        idf_seg = '1;
        idf_seg[SEG_W-1 -: IDF_W] = {idf_head, pen_q, {RSVD_W{1'b0}}, pid_q};
        idf_len = byte_q ? IDF_LEN_B : IDF_LEN_N;

        frm_seg = '1;
        if (desc_comp) begin
            frm_seg[SEG_W-1 -: HEAD_W] = frm_head;
            frm_len = FRC_LEN;
        end else begin
            frm_seg[SEG_W-1 -: FR_U] = {frm_head, {ALIGN_ZEROS{1'b0}}, 1'b1, desc_data};
            frm_len = FRU_LEN;
        end
        frm_len = frm_len + (byte_q ? STP_LEN_B : STP_LEN_N);

        end_seg = '1;
        end_seg[SEG_W-1 -: END_W] = END_WORD;
    end

    // Sequencer: choose the next segment once the shifter has drained.
    always_comb begin
        state_d = state_q;
        sh_load = 1'b0;
        sh_val  = hdr_seg;
        sh_len  = hdr_len;
        unique case (state_q)
            ST_IDLE: if (start) begin
                sh_load = 1'b1;
                state_d = ST_HDR;
            end
            ST_HDR: if (sh_empty) begin
                if (id_q) begin
                    sh_load = 1'b1;
                    sh_val  = idf_seg;
                    sh_len  = idf_len;
                    state_d = ST_IDF;
                end else begin
                    state_d = ST_DWAIT;
                end
            end
            ST_IDF: if (sh_empty) state_d = ST_DWAIT;
            ST_DWAIT: if (desc_valid) begin
                sh_load = 1'b1;
                sh_val  = frm_seg;
                sh_len  = frm_len;
                state_d = ST_DFRM;
            end
            ST_DFRM: if (sh_empty) begin
                if (last_q) begin
                    sh_load = 1'b1;
                    sh_val  = end_seg;
                    sh_len  = END_LEN;
                    state_d = ST_ENDW;
                end else begin
                    state_d = ST_DWAIT;
                end
            end
            ST_ENDW: if (sh_empty) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register plus option and last-frame capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= 1'b0;
            id_q    <= 1'b0;
            pen_q   <= 1'b0;
            pid_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                byte_q <= byte_mode;
                id_q   <= id_en;
                pen_q  <= parity_en;
                pid_q  <= part_id;
            end
            if (desc_valid && desc_ready) last_q <= desc_last;
        end
    end

    assign desc_ready = state_q == ST_DWAIT;
    assign busy       = state_q != ST_IDLE;

    cfg_bit_shifter #(.SEG_W(SEG_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
        .load_len(sh_len), .out_ready(bit_ready), .out_bit(bit_out),
        .out_valid(bit_valid), .empty(sh_empty)
    );

    // R11
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid && !bit_ready |=> bit_valid && $stable(bit_out));

    // R11
    load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |-> sh_empty);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bit_valid && !desc_ready);

    // R10
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ENDW && sh_empty |=> !busy && !bit_valid);

    // R5
    frm_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready |->
            ($countones({frm_fld[11], frm_fld[9], frm_fld[7], frm_fld[5],
                         frm_fld[3], frm_fld[1], frm_opar}) % 2) == 1);

endmodule

// File: tb/cfg_stream_framer_bench.sv
`timescale 1ns/1ps
module cfg_stream_framer_bench;

    localparam int DATA_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, byte_mode = 1'b0, id_en = 1'b0, parity_en = 1'b0;
    logic [19:0] part_id = '0;
    logic [23:0] total_bits = '0;
    logic        desc_valid = 1'b0, desc_comp = 1'b0, desc_all = 1'b0, desc_last = 1'b0;
    logic [10:0] desc_addr = '0;
    logic [DATA_W-1:0] desc_data = '0;
    logic        desc_ready, bit_out, bit_valid, busy;
    logic        bit_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit stall_en = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    logic [10:0]       f_addr[4];
    logic              f_comp[4];
    logic              f_all[4];
    logic [DATA_W-1:0] f_data[4];

    always #2.5 clk = ~clk;

    cfg_stream_framer u_cfg_stream_framer (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
        .id_en(id_en), .parity_en(parity_en), .part_id(part_id),
        .total_bits(total_bits), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_comp(desc_comp), .desc_all(desc_all),
        .desc_last(desc_last), .desc_data(desc_data), .bit_out(bit_out),
        .bit_valid(bit_valid), .bit_ready(bit_ready), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_v(input logic [63:0] v, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) begin
            exp_q.push_back(v[i]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic push_c(input logic b, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(b);
            tag_q.push_back(tag);
        end
    endtask

    // Frame head per R4, parity per R5 computed from first principles.
    task automatic push_head(input logic p, input logic c, input logic [10:0] a, input string tag);
        logic [12:0] f;
        int odd_ones, even_ones;
        f = {p, c, a};
        odd_ones = 0;
        even_ones = 0;
        for (int i = 0; i < 13; i++) begin
            if (f[i]) begin
                if (i % 2 == 1) odd_ones++;
                else even_ones++;
            end
        end
        push_v({59'd0, 1'b0, p, c, (odd_ones % 2 == 0), (even_ones % 2 == 1)}, 5, tag);
        push_v({53'd0, a}, 11, tag);
    endtask

    // Scoreboard monitor: compare accepted bits in order, check the hold rule.
    logic prev_stall = 1'b0;
    logic prev_bit   = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(bit_valid === 1'b1 && bit_out === prev_bit, "R11 hold", int'(bit_out), int'(prev_bit));
            if (bit_valid && bit_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 extra bit", int'(bit_out), -1);
                end else begin
                    logic e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bit_out === e, t, int'(bit_out), int'(e));
                end
            end
            prev_stall = bit_valid && !bit_ready;
            prev_bit   = bit_out;
        end
    end

    // Consumer pacing: always ready, or a pseudo-random stall pattern.
    initial begin
        logic [7:0] lfsr = 8'hA7;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            bit_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
        end
    end

    task automatic run_scn(input logic bm, input logic ide, input logic pen,
                           input logic [19:0] pid, input int nf, input logic stall);
        int total;
        int stp;
        bit acc;
        stp = bm ? 8 : 3;
        total = (bm ? 48 : 36) + (ide ? (bm ? 88 : 83) : 0) + 24;
        for (int k = 0; k < nf; k++)
            total += 16 + (f_comp[k] ? 0 : 2 + 1 + DATA_W) + stp;
        // R2 / R3 header
        push_c(1'b1, bm ? 12 : 4, bm ? "R3" : "R2");
        push_v(64'b0010, 4, bm ? "R3" : "R2");
        push_v(64'(total), 24, bm ? "R3" : "R2");
        push_c(1'b1, bm ? 8 : 4, bm ? "R3" : "R2");
        // R6 identification frame
        if (ide) begin
            push_head(1'b1, 1'b0, 11'h7FF, "R6 R5");
            push_c(pen, 1, "R6");
            push_c(1'b0, 43, "R6");
            push_v(64'(pid), 20, "R6");
            push_c(1'b1, bm ? 8 : 3, "R6");
        end
        // R4 R7 R8 R9 data frames
        for (int k = 0; k < nf; k++) begin
            push_head(~f_all[k], f_comp[k], f_addr[k], "R4 R5");
            if (!f_comp[k]) begin
                push_c(1'b0, 2, "R7");
                push_c(1'b1, 1, "R7");
                push_v(64'(f_data[k]), DATA_W, "R7");
            end
            push_c(1'b1, stp, bm ? "R9" : (f_comp[k] ? "R8" : "R7"));
        end
        // R10 end word and postamble
        push_v(64'b0010011111111111, 16, "R10");
        push_c(1'b1, 8, "R10");

        stall_en = stall;
        @(posedge clk);
        #1;
        start = 1'b1; byte_mode = bm; id_en = ide; parity_en = pen;
        part_id = pid; total_bits = 24'(total);
        @(posedge clk);
        #1;
        start = 1'b0; byte_mode = ~bm; id_en = ~ide; parity_en = ~pen;
        part_id = ~pid; total_bits = '0;
        @(negedge clk);
        check(desc_ready === 1'b0, "R11 ready during header", int'(desc_ready), 0);
        for (int k = 0; k < nf; k++) begin
            @(posedge clk);
            #1;
            desc_valid = 1'b1; desc_addr = f_addr[k]; desc_comp = f_comp[k];
            desc_all = f_all[k]; desc_data = f_data[k]; desc_last = (k == nf - 1);
            do begin
                @(negedge clk);
                acc = desc_ready;
                @(posedge clk);
            end while (!acc);
            #1;
            desc_valid = 1'b0;
            desc_data = ~desc_data;
        end
        while (busy) @(posedge clk);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R10 stream complete", exp_q.size(), 0);
        check(busy === 1'b0 && bit_valid === 1'b0, "R10 idle after end", int'(busy), 0);
        exp_q.delete();
        tag_q.delete();
        stall_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1 busy", int'(busy), 0);
        check(bit_valid === 1'b0, "R1 bit_valid", int'(bit_valid), 0);
        check(desc_ready === 1'b0, "R1 desc_ready", int'(desc_ready), 0);
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && bit_valid === 1'b0, "R1 quiet without start", int'(busy), 0);

        // Normal mode, ID frame, mixed frames, consumer always ready.
        f_addr[0] = 11'h000; f_comp[0] = 1'b0; f_all[0] = 1'b0; f_data[0] = 16'hBEEF;
        f_addr[1] = 11'h155; f_comp[1] = 1'b1; f_all[1] = 1'b0; f_data[1] = 16'h1234;
        f_addr[2] = 11'h2AA; f_comp[2] = 1'b0; f_all[2] = 1'b1; f_data[2] = 16'h0F0F;
        run_scn(1'b0, 1'b1, 1'b1, 20'hA5C3F, 3, 1'b0);

        // Byte mode, no ID frame, stalling consumer.
        f_addr[0] = 11'h001; f_comp[0] = 1'b1; f_all[0] = 1'b0; f_data[0] = 16'hFFFF;
        f_addr[1] = 11'h400; f_comp[1] = 1'b0; f_all[1] = 1'b0; f_data[1] = 16'h8001;
        f_addr[2] = 11'h3FF; f_comp[2] = 1'b0; f_all[2] = 1'b1; f_data[2] = 16'hFFFF;
        f_addr[3] = 11'h7FE; f_comp[3] = 1'b1; f_all[3] = 1'b1; f_data[3] = 16'h5A5A;
        run_scn(1'b1, 1'b0, 1'b0, 20'h00000, 4, 1'b1);

        // Byte mode with ID frame, parity-enable clear, single compressed frame.
        f_addr[0] = 11'h0C3; f_comp[0] = 1'b1; f_all[0] = 1'b0; f_data[0] = 16'hC0DE;
        run_scn(1'b1, 1'b1, 1'b0, 20'h13579, 1, 1'b1);

        // Normal mode without ID frame, stalling consumer.
        f_addr[0] = 11'h7FF; f_comp[0] = 1'b0; f_all[0] = 1'b0; f_data[0] = 16'h0001;
        f_addr[1] = 11'h0AA; f_comp[1] = 1'b1; f_all[1] = 1'b1; f_data[1] = 16'hAAAA;
        run_scn(1'b0, 1'b0, 1'b1, 20'hFFFFF, 2, 1'b1);

        finish_run();
    end

endmodule